// File: doc/BRIEF.md
# Crossbar Forming Sequencer

This block runs the one-time electroforming pass over a square passive resistive crossbar of 32 by 32 cells. It takes the cells one at a time. For each cell it drives one row bias line and one column ground line, and raises a digital forming-voltage code in fixed steps until a current-compliance comparator trips. It then reads the freshly formed cell while it is ON, applies a negative-polarity reset pulse to return the cell to OFF, and reads the cell again. A cell fails when its ON read current is less than three times its OFF read current.

The visiting order starts at the middle of the array and moves outward in concentric square rings, so that cells formed early sit away from the edges. Every formed cell is switched OFF before the sequencer moves on, which keeps leakage from formed neighbours low. A subset mode forms only the cells flagged in a per-cell list and leaves all other cells untouched. The per-cell pass/fail result is held in a failure map that can be read by address. A one-cycle done pulse marks the end of the pass. The analog drivers, the DAC and the current sensing sit outside the block.

Top module: `xbar_form_seq`

## Requirements
- R1: While reset is held and after it is released, the block is idle: driveMode is 0, no row or column line is driven, done is low and every failure-map bit reads 0.
- R2: driveMode encodes 0 = idle (all lines floating), 1 = form, 2 = reset, 3 = read. When driveMode is not 0, exactly one bit of rowDrive and exactly one bit of colGnd are set, and they mark the selected cell. When driveMode is 0, both vectors are all zero.
- R3: Cell address is row*32+col. Cells are visited in rings of Chebyshev distance from the array centre: ring k holds the cells where max(|2r-31|,|2c-31|) >>1 equals k. Rings are taken in rising k, and cells within a ring in row-major order.
- R4: Forming starts at code 8 and rises by 4 on each consecutive form cycle. It stops in the first cycle in which senseTrip is high, and that code is the first ramp value at or above the cell's trip level.
- R5: When the comparator has not tripped by the last ramp code (252, the largest ramp value not above 252), the cell is marked failed and the next cycle is idle, with no read and no reset of that cell.
- R6: After a trip, the next three cycles are: read at code 16, reset at code 160, then read again.
- R7: A formed cell fails when its ON read (readCode in the first read) is less than 3 times its OFF read (second read). A ratio of exactly 3 passes.
- R8: With subsetEn high, a cell whose cellList bit is 0 is never driven and its map bit stays 0. Listed cells keep the order of R3.
- R9: done is high for exactly one cycle after the last cell. The map holds its contents until the next start, which clears it.
- R10: A start pulse during a pass has no effect on the order or on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a forming pass (taken only when idle) |
| subsetEn | input | 1 | Form only cells flagged in cellList |
| cellList | input | 1024 | Per-cell subset flag, bit index = address |
| senseTrip | input | 1 | Compliance comparator flag |
| readCode | input | 12 | Read-current code from the sense path |
| rowDrive | output | 32 | One-hot row bias enable |
| colGnd | output | 32 | One-hot column ground enable |
| driveMode | output | 2 | Line-driver mode, encoding in R2 |
| driveCode | output | 8 | Voltage magnitude code for the drivers |
| mapAddr | input | 10 | Failure-map read address |
| mapFail | output | 1 | Failure bit at mapAddr |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
Two things can happen in the same form cycle: the comparator trip and the ramp reaching its top code. If both happen, the trip must win, so that cell goes on to read and reset and does not time out. Directed trip levels of exactly 252 and 253 provoke this. The bench checks that the first cell forms at code 252 and runs the read-reset-read sequence, and that the second cell goes idle and is marked failed. A second overlap is a start pulse that arrives while a pass is running. The bench judges it by the visit order and the final map, which must match a pass with no second pulse.

// File: rtl/xbf_pkg.sv
package xbf_pkg;

  typedef enum logic [1:0] {
    DRV_IDLE  = 2'd0,
    DRV_FORM  = 2'd1,
    DRV_RESET = 2'd2,
    DRV_READ  = 2'd3
  } drvMode_e;

  typedef struct packed {
    logic orderInit;
    logic orderStep;
    logic codeLoad;
    logic codeInc;
    logic capOn;
    logic capOff;
    logic markFail;
    logic markPass;
  } dpStrobe_t;

endpackage

// File: rtl/xbf_order.sv
module xbf_order #(
  parameter int DIM    = 32,
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              init,
  input  logic              step,
  output logic [IDX_W-1:0]  rowIdx,
  output logic [IDX_W-1:0]  colIdx,
  output logic [ADDR_W-1:0] cellAddr,
  output logic              isLast
);
  localparam int RINGS = (DIM + 1) / 2;
  localparam int LO0   = (DIM - 1) / 2;
  localparam int HI0   = DIM / 2;

  logic [IDX_W-1:0] ringK, rowQ, colQ;
  logic [IDX_W-1:0] lo, hi, loNext;
  logic             edgeRow;

  assign lo      = IDX_W'(LO0) - ringK;
  assign hi      = IDX_W'(HI0) + ringK;
  assign loNext  = lo - IDX_W'(1);
  assign edgeRow = (rowQ == lo) || (rowQ == hi);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ringK <= '0;
      rowQ  <= IDX_W'(LO0);
      colQ  <= IDX_W'(LO0);
    end else if (init) begin
      ringK <= '0;
      rowQ  <= IDX_W'(LO0);
      colQ  <= IDX_W'(LO0);
    end else if (step) begin
      if (colQ == hi) begin
        if (rowQ == hi) begin
          ringK <= ringK + IDX_W'(1);
          rowQ  <= loNext;
          colQ  <= loNext;
        end else begin
          rowQ <= rowQ + IDX_W'(1);
          colQ <= lo;
        end
      end else if (!edgeRow && (colQ == lo)) begin
        colQ <= hi;
      end else begin
        colQ <= colQ + IDX_W'(1);
      end
    end
  end

  assign rowIdx   = rowQ;
  assign colIdx   = colQ;
  assign cellAddr = ADDR_W'(rowQ) * ADDR_W'(DIM) + ADDR_W'(colQ);
  assign isLast   = (ringK == IDX_W'(RINGS - 1)) && (rowQ == hi) && (colQ == hi);

  // R3: the walker never leaves the boundary of its current ring
  a_r3_on_ring_edge: assert property (@(posedge clk) disable iff (!rstN)
    (edgeRow || (colQ == lo) || (colQ == hi)));
  // R3: the position stays inside the ring's bounding box
  a_r3_in_box: assert property (@(posedge clk) disable iff (!rstN)
    (rowQ >= lo) && (rowQ <= hi) && (colQ >= lo) && (colQ <= hi));
  // R3: rings are taken in rising order
  a_r3_ring_rises: assert property (@(posedge clk) disable iff (!rstN)
    (step && !init) |=> (ringK >= $past(ringK)));

endmodule

// File: rtl/xbf_ctrl.sv
module xbf_ctrl
  import xbf_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      subsetEn,
  input  logic      cellListed,
  input  logic      senseTrip,
  input  logic      codeAtMax,
  input  logic      ratioLow,
  input  logic      isLast,
  output dpStrobe_t strb,
  output drvMode_e  mode,
  output logic      done
);
  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_FORM, S_READON, S_RESET,
    S_READOFF, S_JUDGE, S_ADV, S_DONE
  } state_e;

  state_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt  = state;
    strb = '0;
    unique case (state)
      S_IDLE: if (start) begin
        strb.orderInit = 1'b1;
        nxt = S_CHECK;
      end
      S_CHECK: if (subsetEn && !cellListed) begin
        nxt = S_ADV;
      end else begin
        strb.codeLoad = 1'b1;
        nxt = S_FORM;
      end
      S_FORM: if (senseTrip) begin
        nxt = S_READON;
      end else if (codeAtMax) begin
        strb.markFail = 1'b1;
        nxt = S_ADV;
      end else begin
        strb.codeInc = 1'b1;
      end
      S_READON: begin
        strb.capOn = 1'b1;
        nxt = S_RESET;
      end
      S_RESET:   nxt = S_READOFF;
      S_READOFF: begin
        strb.capOff = 1'b1;
        nxt = S_JUDGE;
      end
      S_JUDGE: begin
        if (ratioLow) strb.markFail = 1'b1;
        else          strb.markPass = 1'b1;
        nxt = S_ADV;
      end
      S_ADV: if (isLast) begin
        nxt = S_DONE;
      end else begin
        strb.orderStep = 1'b1;
        nxt = S_CHECK;
      end
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (state)
      S_FORM:            mode = DRV_FORM;
      S_RESET:           mode = DRV_RESET;
      S_READON, S_READOFF: mode = DRV_READ;
      default:           mode = DRV_IDLE;
    endcase
  end

  assign done = (state == S_DONE);

  // R6: a trip leads straight into the ON read
  a_r6_trip_then_read: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FORM && senseTrip) |=> (mode == DRV_READ));
  // R6: the reset pulse is always followed by a read
  a_r6_reset_then_read: assert property (@(posedge clk) disable iff (!rstN)
    (mode == DRV_RESET) |=> (mode == DRV_READ));
  // R5: a ramp that tops out without a trip goes idle, no read or reset
  a_r5_timeout_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FORM && !senseTrip && codeAtMax) |=> (mode == DRV_IDLE));
  // R9: done lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R10: a running pass only returns to idle through the done state
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && state != S_DONE) |=> (state != S_IDLE));

endmodule

// File: rtl/xbf_datapath.sv
module xbf_datapath
  import xbf_pkg::*;
#(
  parameter int DIM        = 32,
  parameter int IDX_W      = 5,
  parameter int ADDR_W     = 10,
  parameter int CELLS      = 1024,
  parameter int CODE_W     = 8,
  parameter int READ_W     = 12,
  parameter int FORM_START = 8,
  parameter int FORM_STEP  = 4,
  parameter int FORM_MAX   = 252,
  parameter int RESET_CODE = 160,
  parameter int READ_LVL   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  drvMode_e          mode,
  input  logic [READ_W-1:0] readCode,
  input  logic [IDX_W-1:0]  rowIdx,
  input  logic [IDX_W-1:0]  colIdx,
  input  logic [ADDR_W-1:0] cellAddr,
  input  logic [ADDR_W-1:0] mapAddr,
  output logic [DIM-1:0]    rowDrive,
  output logic [DIM-1:0]    colGnd,
  output logic [CODE_W-1:0] driveCode,
  output logic              codeAtMax,
  output logic              ratioLow,
  output logic              mapFail
);
  localparam int RW = READ_W + 2;

  logic [CODE_W-1:0] rampCode;
  logic [READ_W-1:0] onCap, offCap;
  logic [CELLS-1:0]  failMap;
  logic [CODE_W:0]   nextSum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rampCode <= '0;
      onCap    <= '0;
      offCap   <= '0;
    end else begin
      if (strb.codeLoad)     rampCode <= CODE_W'(FORM_START);
      else if (strb.codeInc) rampCode <= rampCode + CODE_W'(FORM_STEP);
      if (strb.capOn)  onCap  <= readCode;
      if (strb.capOff) offCap <= readCode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failMap <= '0;
    end else if (strb.orderInit) begin
      failMap <= '0;
    end else if (strb.markFail) begin
      failMap[cellAddr] <= 1'b1;
    end else if (strb.markPass) begin
      failMap[cellAddr] <= 1'b0;
    end
  end

  assign nextSum   = {1'b0, rampCode} + (CODE_W+1)'(FORM_STEP);
  assign codeAtMax = nextSum > (CODE_W+1)'(FORM_MAX);
  assign ratioLow  = RW'(onCap) < (RW'(offCap) * RW'(3));
  assign mapFail   = failMap[mapAddr];

  generate
    for (genvar i = 0; i < DIM; i++) begin : g_line
      assign rowDrive[i] = (mode != DRV_IDLE) && (rowIdx == IDX_W'(i));
      assign colGnd[i]   = (mode != DRV_IDLE) && (colIdx == IDX_W'(i));
    end
  endgenerate

  always_comb begin
    unique case (mode)
      DRV_FORM:  driveCode = rampCode;
      DRV_RESET: driveCode = CODE_W'(RESET_CODE);
      DRV_READ:  driveCode = CODE_W'(READ_LVL);
      default:   driveCode = '0;
    endcase
  end

  // R4: each further form cycle raises the code by one step
  a_r4_ramp_step: assert property (@(posedge clk) disable iff (!rstN)
    (mode == DRV_FORM && $past(mode) == DRV_FORM) |->
      (rampCode == $past(rampCode) + CODE_W'(FORM_STEP)));
  // R4: the first form cycle of a cell applies the start code
  a_r4_ramp_start: assert property (@(posedge clk) disable iff (!rstN)
    (mode == DRV_FORM && $past(mode) != DRV_FORM) |->
      (rampCode == CODE_W'(FORM_START)));
  // R2: a driven mode always selects one row line and one column line
  a_r2_one_pair: assert property (@(posedge clk) disable iff (!rstN)
    (mode != DRV_IDLE) |-> ($countones(rowDrive) == 1 && $countones(colGnd) == 1));

endmodule

// File: rtl/xbar_form_seq.sv
module xbar_form_seq
  import xbf_pkg::*;
#(
  parameter int DIM        = 32,
  parameter int CODE_W     = 8,
  parameter int READ_W     = 12,
  parameter int FORM_START = 8,
  parameter int FORM_STEP  = 4,
  parameter int FORM_MAX   = 252,
  parameter int RESET_CODE = 160,
  parameter int READ_LVL   = 16,
  localparam int CELLS     = DIM * DIM,
  localparam int IDX_W     = (DIM > 1) ? $clog2(DIM) : 1,
  localparam int ADDR_W    = (CELLS > 1) ? $clog2(CELLS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              subsetEn,
  input  logic [CELLS-1:0]  cellList,
  input  logic              senseTrip,
  input  logic [READ_W-1:0] readCode,
  output logic [DIM-1:0]    rowDrive,
  output logic [DIM-1:0]    colGnd,
  output logic [1:0]        driveMode,
  output logic [CODE_W-1:0] driveCode,
  input  logic [ADDR_W-1:0] mapAddr,
  output logic              mapFail,
  output logic              done
);
  dpStrobe_t         strb;
  drvMode_e          modeC;
  logic [IDX_W-1:0]  rowIdx, colIdx;
  logic [ADDR_W-1:0] cellAddr;
  logic              isLast, codeAtMax, ratioLow, cellListed;

  assign cellListed = cellList[cellAddr];
  assign driveMode  = modeC;

  xbf_order #(.DIM(DIM), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_order (
    .clk(clk), .rstN(rstN), .init(strb.orderInit), .step(strb.orderStep),
    .rowIdx(rowIdx), .colIdx(colIdx), .cellAddr(cellAddr), .isLast(isLast)
  );

  xbf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .subsetEn(subsetEn),
    .cellListed(cellListed), .senseTrip(senseTrip), .codeAtMax(codeAtMax),
    .ratioLow(ratioLow), .isLast(isLast), .strb(strb), .mode(modeC), .done(done)
  );

  xbf_datapath #(
    .DIM(DIM), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .CELLS(CELLS),
    .CODE_W(CODE_W), .READ_W(READ_W), .FORM_START(FORM_START),
    .FORM_STEP(FORM_STEP), .FORM_MAX(FORM_MAX), .RESET_CODE(RESET_CODE),
    .READ_LVL(READ_LVL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mode(modeC), .readCode(readCode),
    .rowIdx(rowIdx), .colIdx(colIdx), .cellAddr(cellAddr), .mapAddr(mapAddr),
    .rowDrive(rowDrive), .colGnd(colGnd), .driveCode(driveCode),
    .codeAtMax(codeAtMax), .ratioLow(ratioLow), .mapFail(mapFail)
  );

endmodule

// File: tb/sim_xbar_form_seq.sv
module sim_xbar_form_seq;
  localparam int DIM = 32, CELLS = DIM * DIM, READ_W = 12;
  localparam int START = 8, STEP = 4, MAXC = 252, RST_C = 160, RD_C = 16;
  localparam int LASTCODE = START + ((MAXC - START) / STEP) * STEP;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, subsetEn = 1'b0;
  logic [CELLS-1:0] cellList = '0;
  logic senseTrip;
  logic [READ_W-1:0] readCode;
  logic [DIM-1:0] rowDrive, colGnd;
  logic [1:0] driveMode;
  logic [7:0] driveCode;
  logic [9:0] mapAddr = '0;
  logic mapFail, done;

  int thrTab[CELLS], onTab[CELLS], offTab[CELLS];
  bit cellOn[CELLS];
  int expOrder[$];
  int nChecks = 0, nErr = 0;
  int mRow, mCol, mAddr;
  int lastAddr = -1, visIdx = 0, prevCode = 0, seqPos = 0;
  bit inRun = 1'b0;

  always #2 clk = ~clk;

  xbar_form_seq u0 (
    .clk(clk), .rstN(rstN), .start(start), .subsetEn(subsetEn),
    .cellList(cellList), .senseTrip(senseTrip), .readCode(readCode),
    .rowDrive(rowDrive), .colGnd(colGnd), .driveMode(driveMode),
    .driveCode(driveCode), .mapAddr(mapAddr), .mapFail(mapFail), .done(done)
  );

  // sense-path model
  always_comb begin
    mRow = 0;
    mCol = 0;
    for (int i = 0; i < DIM; i++) begin
      if (rowDrive[i]) mRow = i;
      if (colGnd[i])   mCol = i;
    end
    mAddr     = mRow * DIM + mCol;
    senseTrip = (driveMode == 2'd1) && (int'(driveCode) >= thrTab[mAddr]);
    readCode  = cellOn[mAddr] ? READ_W'(onTab[mAddr]) : READ_W'(offTab[mAddr]);
  end

  always @(posedge clk) begin
    if (driveMode == 2'd1 && senseTrip) cellOn[mAddr] <= 1'b1;
    else if (driveMode == 2'd2)         cellOn[mAddr] <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int absI(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int ringOf(input int r, input int c);
    int dr = absI(2 * r - (DIM - 1));
    int dc = absI(2 * c - (DIM - 1));
    return ((dr > dc) ? dr : dc) / 2;
  endfunction

  function automatic int expTrip(input int thr);
    for (int code = START; code <= MAXC; code += STEP)
      if (code >= thr) return code;
    return -1;
  endfunction

  function automatic bit expFail(input int a);
    if (expTrip(thrTab[a]) < 0) return 1'b1;
    return onTab[a] < 3 * offTab[a];
  endfunction

  task automatic buildOrder(input bit sub);
    expOrder.delete();
    for (int k = 0; k < (DIM + 1) / 2; k++)
      for (int r = 0; r < DIM; r++)
        for (int c = 0; c < DIM; c++)
          if (ringOf(r, c) == k && (!sub || cellList[r * DIM + c]))
            expOrder.push_back(r * DIM + c);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  endtask

  // monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rstN && inRun) begin
      if (driveMode == 2'd0)
        chk(rowDrive == '0 && colGnd == '0, "R2 idle lines", $countones(rowDrive), 0);
      else
        chk($countones(rowDrive) == 1 && $countones(colGnd) == 1, "R2 one line pair",
            $countones(rowDrive) + $countones(colGnd), 2);
      case (seqPos)
        1: begin chk(driveMode == 2'd3 && driveCode == RD_C, "R6 on read", driveMode, 3); seqPos = 2; end
        2: begin chk(driveMode == 2'd2 && driveCode == RST_C, "R6 reset", driveCode, RST_C); seqPos = 3; end
        3: begin chk(driveMode == 2'd3, "R6 off read", driveMode, 3); seqPos = 0; end
        10: begin chk(driveMode == 2'd0, "R5 timeout idle", driveMode, 0); seqPos = 0; end
        default: ;
      endcase
      if (driveMode == 2'd1) begin
        if (mAddr != lastAddr) begin
          chk(visIdx < expOrder.size() && mAddr == expOrder[visIdx], "R3 visit order",
              mAddr, (visIdx < expOrder.size()) ? expOrder[visIdx] : -1);
          if (subsetEn) chk(cellList[mAddr], "R8 listed only", mAddr, 1);
          chk(driveCode == START, "R4 start code", driveCode, START);
          lastAddr = mAddr;
          visIdx++;
        end else begin
          chk(int'(driveCode) == prevCode + STEP, "R4 ramp step", driveCode, prevCode + STEP);
        end
        prevCode = driveCode;
        if (senseTrip) begin
          chk(int'(driveCode) == expTrip(thrTab[mAddr]), "R4 trip code", driveCode,
              expTrip(thrTab[mAddr]));
          seqPos = 1;
        end else if (driveCode == LASTCODE) begin
          seqPos = 10;
        end
      end
    end
  end

  task automatic runPass(input bit sub, input bit extraStart);
    buildOrder(sub);
    subsetEn = sub;
    lastAddr = -1;
    visIdx = 0;
    seqPos = 0;
    inRun = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (extraStart) begin
      repeat (400) @(negedge clk);
      start = 1'b1;                         // R10: ignored mid-pass
      @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(done, "R9 done seen", done, 1);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
    inRun = 1'b0;
    chk(visIdx == expOrder.size(), sub ? "R8 visit count" : "R3 visit count",
        visIdx, expOrder.size());
    for (int a = 0; a < CELLS; a++) begin
      bit e;
      mapAddr = 10'(a);
      #1;
      if (sub && !cellList[a]) begin
        chk(mapFail == 1'b0, "R8 unlisted map zero", mapFail, 0);
      end else begin
        e = expFail(a);
        if (expTrip(thrTab[a]) < 0) chk(mapFail == e, "R5 timeout map", mapFail, e);
        else                         chk(mapFail == e, "R7 ratio map", mapFail, e);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < CELLS; a++) begin
      thrTab[a] = 8 + int'($urandom % 90);
      onTab[a]  = 600 + int'($urandom % 300);
      offTab[a] = 40 + int'($urandom % 120);
      cellOn[a] = 1'b0;
      cellList[a] = ($urandom % 10) == 0;
      if (a % 53 == 0) thrTab[a] = 300;                          // R5 never trips
      if (a % 47 == 3) begin offTab[a] = 200; onTab[a] = 600; end // R7 exactly 3 passes
      if (a % 47 == 4) begin offTab[a] = 201; onTab[a] = 602; end // R7 just below fails
    end
    thrTab[528] = 8;     // trips on the first code
    thrTab[527] = 252;   // trip and top code in the same cycle
    thrTab[496] = 253;   // tops out, fails
    cellList[528] = 1'b1;
    cellList[527] = 1'b1;
    cellList[496] = 1'b1;

    repeat (3) @(negedge clk);
    chk(driveMode == 2'd0 && rowDrive == '0 && colGnd == '0, "R1 reset idle", driveMode, 0);
    chk(!done, "R1 reset done low", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int a = 0; a < CELLS; a += 97) begin
      mapAddr = 10'(a);
      #1;
      chk(mapFail == 1'b0, "R1 map clear", mapFail, 0);
    end
    chk(driveMode == 2'd0, "R1 idle after reset", driveMode, 0);

    runPass(1'b0, 1'b1);
    repeat (5) @(negedge clk);
    mapAddr = 10'(496);
    #1;
    chk(mapFail == 1'b1, "R9 map held", mapFail, 1);
    runPass(1'b1, 1'b0);
    finishRun();
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    finishRun();
  end

endmodule